// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block holds in-flight micro-operations for two hardware threads and returns them to the architectural state in program order. One allocation is accepted per cycle, tagged with a thread bit. The entry index it returns is the thread bit followed by a slot number. Each thread owns a private half of the storage, run as a circular queue with its own head and tail. Completion ports mark entries finished out of order, given the entry index, and carry an exception flag and the branch outcome.

Each cycle, a retirement stage picks one thread. From that thread it emits up to three of the oldest entries, as long as they form an unbroken run of completed entries. The selector alternates between the threads while both can retire. When only one thread can retire, that thread gets every retire slot. Each retired entry carries its index, destination register, branch flag, taken bit and resolved target. A downstream branch target buffer uses the branch fields. A faulting head entry halts its thread and raises an exception flag. A per-thread flush empties that thread's half.

Top module: `rob2t`

## Requirements
- R1: Each thread owns HALF (16) entries. The allocation index is {thread bit, slot}, and slots are handed out in sequence from 0 after reset or flush, wrapping modulo HALF. `alloc_stall[t]` is high exactly when thread t holds HALF entries. A request to a stalled thread is ignored and does not advance its slot sequence.
- R2: An entry retires only after a completion has marked it done. An incomplete head blocks retirement of its thread, even when younger entries are done.
- R3: Within a thread, entries retire in allocation order. The retired group is the oldest contiguous run of completed entries and stops at the first incomplete one.
- R4: At most three entries retire per cycle. `ret_vld` is always a prefix of ones (000, 001, 011 or 111).
- R5: All entries retired in one cycle belong to thread `ret_tid`, and the top bit of each `ret_idx` equals `ret_tid`.
- R6: When both threads have a retirable head, the selected thread is the one that did not retire most recently. After reset, thread 0 goes first.
- R7: When only one thread has a retirable head, it is selected regardless of history, and it may retire three entries in consecutive cycles.
- R8: Each retired entry reports the destination and branch flag given at allocation, plus the taken bit and target given at completion.
- R9: A completed head entry marked with an exception raises `exc_out[t]` and is never retired. Its thread stops retiring, while the other thread continues.
- R10: `flush[t]` suppresses any retirement of thread t in that cycle. On the following cycle, thread t is empty, its slot sequence restarts at 0, and `exc_out[t]` and `alloc_stall[t]` are low. The other thread is unaffected.
- R11: After reset, no retirement is signalled and both stall and both exception outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Allocation request |
| alloc_tid | input | 1 | Thread of the allocation |
| alloc_dst | input | DST_W | Destination register of the micro-op |
| alloc_br | input | 1 | Micro-op is a branch |
| alloc_idx | output | SW+1 | Entry index granted to the request |
| alloc_stall | output | 2 | Per-thread full indication |
| cmp_vld | input | NCMP | Completion valid, one per port |
| cmp_idx | input | NCMP*(SW+1) | Entry index of each completion |
| cmp_exc | input | NCMP | Completion raised an exception |
| cmp_taken | input | NCMP | Branch taken outcome |
| cmp_tgt | input | NCMP*TGT_W | Resolved branch target |
| flush | input | 2 | Per-thread flush |
| ret_vld | output | RET_W | Retire slot valid, prefix of ones |
| ret_tid | output | 1 | Thread of this cycle's retirements |
| ret_idx | output | RET_W*(SW+1) | Entry index per retire slot |
| ret_dst | output | RET_W*DST_W | Destination per retire slot |
| ret_br | output | RET_W | Branch flag per retire slot |
| ret_taken | output | RET_W | Taken bit per retire slot |
| ret_tgt | output | RET_W*TGT_W | Target per retire slot |
| exc_out | output | 2 | Per-thread faulting head |

## Verification
The bench completes entries youngest-first, so nothing may leave until the head finishes. A design that ignored the head's done bit would retire early, and one that skipped an incomplete middle entry would break the order. It releases both threads' heads in the same cycle to check strict alternation. It then drains a single thread with the other idle; a selector that forced alternation would stall there. It fills one half, offers a seventeenth request, and later checks the slot number, so a design that accepted the extra entry shows a shifted index. A faulting head and a flush that coincides with ready entries expose a thread that keeps retiring past an exception, or retirements that escape a flush.

// File: rtl/rob2t.sv
module rob2t #(
  parameter int HALF  = 16,
  parameter int DST_W = 5,
  parameter int TGT_W = 32,
  parameter int NCMP  = 2,
  parameter int RET_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_vld,
  input  logic                     alloc_tid,
  input  logic [DST_W-1:0]         alloc_dst,
  input  logic                     alloc_br,
  output logic [$clog2(HALF):0]    alloc_idx,
  output logic [1:0]               alloc_stall,
  input  logic [NCMP-1:0]          cmp_vld,
  input  logic [NCMP*($clog2(HALF)+1)-1:0] cmp_idx,
  input  logic [NCMP-1:0]          cmp_exc,
  input  logic [NCMP-1:0]          cmp_taken,
  input  logic [NCMP*TGT_W-1:0]    cmp_tgt,
  input  logic [1:0]               flush,
  output logic [RET_W-1:0]         ret_vld,
  output logic                     ret_tid,
  output logic [RET_W*($clog2(HALF)+1)-1:0] ret_idx,
  output logic [RET_W*DST_W-1:0]   ret_dst,
  output logic [RET_W-1:0]         ret_br,
  output logic [RET_W-1:0]         ret_taken,
  output logic [RET_W*TGT_W-1:0]   ret_tgt,
  output logic [1:0]               exc_out
);
  localparam int SW = $clog2(HALF);
  localparam int IW = SW + 1;
  localparam int N  = 2 * HALF;
  localparam int CW = $clog2(RET_W + 1);

  logic [N-1:0]       e_vld, e_done, e_exc, e_br, e_tk;
  logic [DST_W-1:0]   e_dst [N];
  logic [TGT_W-1:0]   e_tgt [N];
  logic [SW:0]        head [2];
  logic [SW:0]        tail [2];
  logic               last_tid;

  logic [SW:0]        cnt [2];
  logic [IW-1:0]      hidx [2];
  logic [1:0]         rdy;
  logic               sel;
  logic [IW-1:0]      rk [RET_W];
  logic [RET_W-1:0]   ok;
  logic [CW-1:0]      n_ret;
  logic               alloc_go;

  assign alloc_idx = {alloc_tid, tail[alloc_tid][SW-1:0]};
  assign alloc_go  = alloc_vld && !alloc_stall[alloc_tid] && !flush[alloc_tid];
  assign sel       = (rdy[0] && rdy[1]) ? ~last_tid : rdy[1];
  assign ret_vld   = ok;
  assign ret_tid   = sel;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      cnt[t]         = tail[t] - head[t];
      alloc_stall[t] = (cnt[t] == (SW+1)'(HALF));
      hidx[t]        = {1'(t), head[t][SW-1:0]};
      exc_out[t]     = e_vld[hidx[t]] && e_done[hidx[t]] && e_exc[hidx[t]];
      rdy[t]         = e_vld[hidx[t]] && e_done[hidx[t]] && !e_exc[hidx[t]] && !flush[t];
    end
  end

  always_comb begin
    n_ret = '0;
    for (int k = 0; k < RET_W; k++) begin
      rk[k] = {sel, head[sel][SW-1:0] + SW'(k)};
      ok[k] = ((k == 0) ? rdy[sel] : ok[(k == 0) ? 0 : k-1])
              && e_vld[rk[k]] && e_done[rk[k]] && !e_exc[rk[k]];
      n_ret = n_ret + CW'(ok[k]);
      ret_idx[k*IW +: IW]       = rk[k];
      ret_dst[k*DST_W +: DST_W] = e_dst[rk[k]];
      ret_br[k]                 = e_br[rk[k]];
      ret_taken[k]              = e_tk[rk[k]];
      ret_tgt[k*TGT_W +: TGT_W] = e_tgt[rk[k]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld    <= '0;
      e_done   <= '0;
      e_exc    <= '0;
      head[0]  <= '0;
      head[1]  <= '0;
      tail[0]  <= '0;
      tail[1]  <= '0;
      last_tid <= 1'b1;
    end else begin
      for (int k = 0; k < RET_W; k++)
        if (ok[k]) e_vld[rk[k]] <= 1'b0;
      if (|ok) begin
        head[sel] <= head[sel] + (SW+1)'(n_ret);
        last_tid  <= sel;
      end
      if (alloc_go) begin
        e_vld[alloc_idx]  <= 1'b1;
        e_done[alloc_idx] <= 1'b0;
        e_exc[alloc_idx]  <= 1'b0;
        tail[alloc_tid]   <= tail[alloc_tid] + 1'b1;
      end
      for (int c = 0; c < NCMP; c++) begin
        if (cmp_vld[c] && e_vld[cmp_idx[c*IW +: IW]]) begin
          e_done[cmp_idx[c*IW +: IW]] <= 1'b1;
          e_exc[cmp_idx[c*IW +: IW]]  <= cmp_exc[c];
        end
      end
      for (int t = 0; t < 2; t++) begin
        if (flush[t]) begin
          for (int s = 0; s < HALF; s++) e_vld[{1'(t), SW'(s)}] <= 1'b0;
          head[t] <= '0;
          tail[t] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_go) begin
      e_dst[alloc_idx] <= alloc_dst;
      e_br[alloc_idx]  <= alloc_br;
    end
    for (int c = 0; c < NCMP; c++) begin
      if (cmp_vld[c] && e_vld[cmp_idx[c*IW +: IW]]) begin
        e_tk[cmp_idx[c*IW +: IW]]  <= cmp_taken[c];
        e_tgt[cmp_idx[c*IW +: IW]] <= cmp_tgt[c*TGT_W +: TGT_W];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] <= (SW+1)'(HALF) && cnt[1] <= (SW+1)'(HALF)) else $error("half overfilled"); // R1
  AST_RET_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_vld + 1'b1) & ret_vld) == '0) else $error("retire slots not contiguous"); // R4
  AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|ret_vld) && rdy[0] && rdy[1]) |-> ret_tid != $past(ret_tid)) else $error("no alternation"); // R6
  AST_EXC_HALT0: assert property (@(posedge clk) disable iff (!rst_n)
    exc_out[0] |-> !(ret_vld[0] && !ret_tid)) else $error("thread 0 retired past fault"); // R9
  AST_EXC_HALT1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_out[1] |-> !(ret_vld[0] && ret_tid)) else $error("thread 1 retired past fault"); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush[0] |=> (!alloc_stall[0] && !exc_out[0])) else $error("flush left state"); // R10
endmodule

// File: tb/rob2t_tb.sv
`timescale 1ns/100ps
module rob2t_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        alloc_vld = 0, alloc_tid = 0, alloc_br = 0;
  logic [4:0]  alloc_dst = 0;
  logic [4:0]  alloc_idx;
  logic [1:0]  alloc_stall;
  logic [1:0]  cmp_vld = 0, cmp_exc = 0, cmp_taken = 0;
  logic [9:0]  cmp_idx = 0;
  logic [63:0] cmp_tgt = 0;
  logic [1:0]  flush = 0;
  logic [2:0]  ret_vld, ret_br, ret_taken;
  logic        ret_tid;
  logic [14:0] ret_idx, ret_dst;
  logic [95:0] ret_tgt;
  logic [1:0]  exc_out;

  rob2t dut_i (.clk, .rst_n, .alloc_vld, .alloc_tid, .alloc_dst, .alloc_br, .alloc_idx,
    .alloc_stall, .cmp_vld, .cmp_idx, .cmp_exc, .cmp_taken, .cmp_tgt, .flush, .ret_vld,
    .ret_tid, .ret_idx, .ret_dst, .ret_br, .ret_taken, .ret_tgt, .exc_out);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int q0[$], q1[$], log_tid[$], log_cnt[$];
  int btail[2];
  logic [4:0]  x_dst[32];
  logic        x_br[32], x_tk[32];
  logic [31:0] x_tgt[32];
  int mc, e;
  logic [4:0] ri;

  task automatic chk(input string req, input bit good, input longint act, input longint exp, input string what);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic look(); @(negedge clk); endtask

  function automatic logic [31:0] tg(input int i);
    return 32'hB000_0000 ^ (i * 32'h1111);
  endfunction

  always @(negedge clk) begin
    if (rst_n && |ret_vld) begin
      mc = 0;
      for (int k = 0; k < 3; k++) begin
        if (ret_vld[k]) begin
          ri = ret_idx[k*5 +: 5];
          mc++;
          chk("R5", ri[4] == ret_tid, ri[4], ret_tid, "retire thread");
          if ((ret_tid ? q1.size() : q0.size()) == 0) chk("R3", 0, ri, 0, "unexpected retire");
          else begin
            e = ret_tid ? q1.pop_front() : q0.pop_front();
            chk("R3", ri == e, ri, e, "retire order");
            chk("R8", ret_dst[k*5 +: 5] == x_dst[e] && ret_br[k] == x_br[e] &&
                ret_taken[k] == x_tk[e] && ret_tgt[k*32 +: 32] == x_tgt[e],
                ret_tgt[k*32 +: 32], x_tgt[e], "retire payload");
          end
        end
      end
      log_tid.push_back(int'(ret_tid));
      log_cnt.push_back(mc);
    end
  end

  task automatic alloc(input bit t, input logic [4:0] d, input bit br, output int idx);
    bit full;
    full = ((t ? q1.size() : q0.size()) == 16);
    idx = t * 16 + btail[t];
    alloc_vld = 1; alloc_tid = t; alloc_dst = d; alloc_br = br;
    #0.5;
    chk("R1", alloc_stall[t] == full, alloc_stall[t], full, "stall");
    if (!full) begin
      chk("R1", alloc_idx == idx, alloc_idx, idx, "alloc index");
      x_dst[idx] = d; x_br[idx] = br; x_tk[idx] = 0; x_tgt[idx] = 0;
      if (t) q1.push_back(idx); else q0.push_back(idx);
      btail[t] = (btail[t] + 1) % 16;
    end
    cyc();
    alloc_vld = 0;
  endtask

  task automatic cmpx(input int a, input bit ea, input int b);
    cmp_vld = 2'b01; cmp_exc = {1'b0, ea};
    cmp_idx[4:0] = 5'(a); cmp_taken[0] = a[0]; cmp_tgt[31:0] = tg(a);
    x_tk[a] = a[0]; x_tgt[a] = tg(a);
    if (b >= 0) begin
      cmp_vld[1] = 1; cmp_idx[9:5] = 5'(b); cmp_taken[1] = b[0]; cmp_tgt[63:32] = tg(b);
      x_tk[b] = b[0]; x_tgt[b] = tg(b);
    end
    cyc();
    cmp_vld = 0; cmp_exc = 0;
  endtask

  task automatic do_flush(input bit t);
    flush[t] = 1;
    if (t) q1.delete(); else q0.delete();
    btail[t] = 0;
    look();
    chk("R10", !(|ret_vld && ret_tid == t), ret_vld, 0, "retire masked by flush");
    cyc();
    flush = 0;
    look();
    chk("R10", !alloc_stall[t] && !exc_out[t], {alloc_stall, exc_out}, 0, "flush clears state");
    cyc();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int a[16], b[16], d;
    btail[0] = 0; btail[1] = 0;
    repeat (3) cyc();
    rst_n = 1;
    look();
    chk("R11", ret_vld == 0 && alloc_stall == 0 && exc_out == 0, {ret_vld, alloc_stall, exc_out}, 0, "reset state");
    cyc();

    // R2 R3 R4 R8: out-of-order completion on thread 0
    for (int i = 0; i < 4; i++) alloc(0, 5'(i + 3), i == 1, a[i]);
    cmpx(a[2], 0, a[3]);
    look(); chk("R2", ret_vld == 0, ret_vld, 0, "incomplete head blocks");
    cyc();
    cmpx(a[0], 0, -1);
    look(); chk("R3", ret_vld == 3'b001 && ret_tid == 0, ret_vld, 1, "stop at first incomplete");
    cyc();
    cmpx(a[1], 0, -1);
    look(); chk("R4", ret_vld == 3'b111, ret_vld, 7, "three per cycle");
    cyc();
    repeat (3) cyc();

    // R6: both threads ready together
    for (int i = 0; i < 6; i++) begin alloc(0, 5'(i), 0, a[i]); alloc(1, 5'(i + 10), i == 2, b[i]); end
    for (int i = 5; i >= 1; i--) cmpx(a[i], 0, b[i]);
    log_tid.delete(); log_cnt.delete();
    cmpx(a[0], 0, b[0]);
    repeat (6) cyc();
    chk("R6", log_tid.size() == 4, log_tid.size(), 4, "retire cycles");
    if (log_tid.size() == 4) begin
      chk("R6", log_tid[0] == 1, log_tid[0], 1, "other thread first");
      for (int i = 1; i < 4; i++) chk("R6", log_tid[i] != log_tid[i-1], log_tid[i], 1 - log_tid[i-1], "alternation");
      for (int i = 0; i < 4; i++) chk("R4", log_cnt[i] == 3, log_cnt[i], 3, "group size");
    end

    // R7: one thread alone, repeated after itself
    for (int i = 0; i < 6; i++) alloc(0, 5'(i + 20), i == 4, a[i]);
    cmpx(a[5], 0, a[4]); cmpx(a[3], 0, a[2]); cmpx(a[1], 0, -1);
    log_tid.delete(); log_cnt.delete();
    cmpx(a[0], 0, -1);
    repeat (4) cyc();
    chk("R7", log_tid.size() == 2, log_tid.size(), 2, "cycles used");
    if (log_tid.size() == 2)
      for (int i = 0; i < 2; i++) chk("R7", log_tid[i] == 0 && log_cnt[i] == 3, log_cnt[i], 3, "full bandwidth");

    // R1: fill thread 1, extra request ignored
    for (int i = 0; i < 16; i++) alloc(1, 5'(i), 0, b[i]);
    look(); chk("R1", alloc_stall == 2'b10, alloc_stall, 2, "only thread 1 full");
    cyc();
    alloc(1, 5'd31, 0, d);
    alloc(0, 5'd7, 1, a[0]);
    chk("R1", a[0] == 0, a[0], 0, "thread 0 slot wraps");
    for (int i = 0; i < 16; i += 2) cmpx(b[i], 0, b[i+1]);
    cmpx(a[0], 0, -1);
    repeat (10) cyc();
    chk("R3", q0.size() == 0 && q1.size() == 0, q0.size() + q1.size(), 0, "all drained");
    alloc(1, 5'd9, 0, b[0]);
    cmpx(b[0], 0, -1);
    repeat (3) cyc();

    // R9: faulting head on thread 0
    for (int i = 0; i < 3; i++) alloc(0, 5'(i), 0, a[i]);
    for (int i = 0; i < 2; i++) alloc(1, 5'(i + 4), 0, b[i]);
    cmpx(a[0], 1, a[1]);
    cmpx(a[2], 0, -1);
    look(); chk("R9", exc_out == 2'b01 && ret_vld == 0, {exc_out, ret_vld}, 5'b01000, "fault halts thread");
    cyc();
    log_tid.delete(); log_cnt.delete();
    cmpx(b[0], 0, b[1]);
    repeat (4) cyc();
    chk("R9", log_tid.size() == 1 && log_tid[0] == 1 && log_cnt[0] == 2, log_tid.size(), 1, "other thread proceeds");
    look(); chk("R9", exc_out[0] == 1, exc_out, 1, "fault persists");
    cyc();

    // R10: flush
    do_flush(0);
    alloc(0, 5'd1, 0, a[0]);
    alloc(0, 5'd2, 1, a[1]);
    alloc(1, 5'd3, 0, b[0]);
    chk("R10", a[0] == 0, a[0], 0, "slot restarts");
    cmpx(a[0], 0, a[1]);
    do_flush(0);
    cmpx(b[0], 0, -1);
    repeat (5) cyc();
    chk("R10", q0.size() == 0 && q1.size() == 0, q0.size() + q1.size(), 0, "other thread intact");
    alloc(0, 5'd5, 0, a[0]);
    chk("R10", a[0] == 0, a[0], 0, "slot restarts after masked flush");
    cmpx(a[0], 0, -1);
    repeat (4) cyc();
    chk("R3", q0.size() == 0, q0.size(), 0, "final drain");

    summary();
    $finish;
  end
endmodule